// File: doc/BRIEF.md
# Thresholded Transfer FIFO with DMA Request

This block sits on the data path between a disk controller core and the host bus. Bytes coming from the medium are pushed in by the core and drained by the host. Bytes going to the medium are written by the host and popped by the core. Storage is a FIFO of `DEPTH` bytes.

After reset the FIFO is switched off and the block works as a one-byte holding register. In that state every byte needs its own host or DMA cycle. When the FIFO is switched on, a 4-bit code sets the request threshold. The threshold is the code plus one. A request is raised once that many bytes are waiting to be drained, or that much free space is ready to be filled.

Requests go out on one of two outputs:
- `svc_req` when the host moves data by programmed cycles.
- `drq` when DMA is enabled. DMA runs in single-transfer style or in burst style. The third transfer kind, verify, completes the DMA handshake, discards the data and never drives the host data bus.

Top module: `xfer_fifo_dma`

## Requirements
- R1: After reset, `level` is 0 and `drq`, `svc_req`, `xrun`, `host_rdata_oe` and `core_rvalid` are all 0.
- R2: With `cfg_fifo_en`=0 the block holds at most one byte and the threshold is 1. A core push while one byte is held is dropped and raises `xrun`.
- R3: With `cfg_fifo_en`=1 the block holds up to 16 bytes (`DEPTH`). Two core-side errors are dropped and pulse `xrun` high in the cycle after the access: a push when 16 bytes are held, and a pop while empty. `level` is left unchanged in both cases.
- R4: The threshold is `cfg_thr_code`+1. When draining (read or verify), the request is active while `level` is at least the threshold. When filling (write), it is active while free space (capacity minus `level`) is at least the threshold. The request output updates on the same edge as `level`.
- R5: With `cfg_dma_en`=0, `drq` stays 0 and the request appears on `svc_req`. Host strobes move data without `dack`.
- R6: With `cfg_dma_en`=1, `svc_req` stays 0 and the request appears on `drq`. Only host strobes qualified by `dack` move data.
- R7: In single-transfer style (`cfg_burst_en`=0), `drq` is 0 in the cycle after each `dack`-qualified beat. It rises again on the next edge if the threshold condition still holds.
- R8: In burst style, `drq` stays high across beats, even when the level passes the threshold. It falls only after the beat that empties the FIFO (drain) or fills it (fill).
- R9: Read transfer (`xfer_mode`=0): bytes reach the host in push order on `host_rdata`, with `host_rdata_oe` high for one cycle, in the cycle after the read beat.
- R10: Write transfer (`xfer_mode`=1): host-written bytes come out on `core_rdata` in order, with `core_rvalid` high in the cycle after `core_pop`.
- R11: Verify transfer (`xfer_mode`=2): a `dack` read beat removes one byte. `host_rdata_oe` stays 0 and `host_rdata` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1 = FIFO on, 0 = one-byte bypass |
| cfg_thr_code | input | 4 | Threshold minus one |
| cfg_dma_en | input | 1 | Route requests to DMA |
| cfg_burst_en | input | 1 | Burst DMA style |
| xfer_mode | input | 2 | 0 read, 1 write, 2 verify |
| core_push | input | 1 | Core writes a byte (read/verify) |
| core_wdata | input | 8 | Core write data |
| core_pop | input | 1 | Core takes a byte (write) |
| core_rdata | output | 8 | Byte taken by the core |
| core_rvalid | output | 1 | `core_rdata` valid |
| host_rd | input | 1 | Host/DMA read strobe |
| host_wr | input | 1 | Host/DMA write strobe |
| host_wdata | input | 8 | Host write data |
| dack | input | 1 | DMA acknowledge |
| host_rdata | output | 8 | Read data, 0 unless valid |
| host_rdata_oe | output | 1 | Host data bus driven |
| drq | output | 1 | DMA request |
| svc_req | output | 1 | Programmed-transfer service request |
| xrun | output | 1 | Core overrun/underrun pulse |
| level | output | 5 | Bytes held |

## Verification
The bench pushes one byte too many in bypass mode and in full mode. A block that ignored capacity would accept the byte, corrupt the order and leave `xrun` low.

It crosses the threshold one byte at a time in both directions. An off-by-one in the code decoding would show as a request one byte early or late.

In single style it checks the one-cycle `drq` gap and the re-rise. In burst style it checks that `drq` survives a beat that takes the level below the threshold, which catches a burst that quits early. It also checks that `drq` ends on the emptying or filling beat.

Verify beats are checked to remove data without ever enabling the host bus. Strobes without `dack` in DMA mode are checked to move nothing.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  typedef enum logic [1:0] {
    XM_READ   = 2'd0,
    XM_WRITE  = 2'd1,
    XM_VERIFY = 2'd2,
    XM_RSVD   = 2'd3
  } xmode_e;

  function automatic logic mode_fills(xmode_e m);
    return m == XM_WRITE;
  endfunction

  function automatic logic mode_quiet(xmode_e m);
    return m == XM_VERIFY;
  endfunction
endpackage

// File: rtl/xfd_store.sv
module xfd_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] lvl,
  output logic [CW-1:0] lvl_nxt,
  output logic          full,
  output logic          empty,
  output logic          acc_push,
  output logic          acc_pop
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full     = lvl >= cap;
  assign empty    = lvl == '0;
  assign acc_push = push && !full;
  assign acc_pop  = pop && !empty;
  assign lvl_nxt  = lvl + CW'(acc_push) - CW'(acc_pop);

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (acc_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (acc_pop) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl    <= '0;
    end else begin
      if (acc_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (acc_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      lvl <= lvl_nxt;
    end
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    lvl <= CW'(DEPTH));
  p_empty_pop_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> $stable(lvl));
  p_full_push_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(lvl));
endmodule

// File: rtl/xfd_req.sv
module xfd_req #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          burst_en,
  input  logic          fill,
  input  logic          beat,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] lvl_nxt,
  output logic          svc_req,
  output logic          drq
);
  logic [CW-1:0] avail;
  logic          cond, burst_end;

  assign avail     = fill ? (cap - lvl_nxt) : lvl_nxt;
  assign cond      = avail >= thr;
  assign burst_end = fill ? (lvl_nxt >= cap) : (lvl_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) svc_req <= 1'b0;
    else     svc_req <= !dma_en && cond;
  end

  always_ff @(posedge clk) begin
    if (rst || !dma_en) drq <= 1'b0;
    else if (drq) begin
      if (beat) drq <= burst_en && !burst_end;
    end else drq <= cond;
  end

  p_pio_no_drq_r5: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !drq);
  p_dma_no_svc_r6: assert property (@(posedge clk) disable iff (rst)
    dma_en |=> !svc_req);
  p_single_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (dma_en && !burst_en && drq && beat) |=> !drq);
  p_burst_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dma_en && burst_en && drq && beat && !burst_end) |=> drq);
endmodule

// File: rtl/xfer_fifo_dma.sv
module xfer_fifo_dma
  import xfd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_fifo_en,
  input  logic [AW-1:0] cfg_thr_code,
  input  logic          cfg_dma_en,
  input  logic          cfg_burst_en,
  input  logic [1:0]    xfer_mode,
  input  logic          core_push,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_pop,
  output logic [DW-1:0] core_rdata,
  output logic          core_rvalid,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          dack,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_oe,
  output logic          drq,
  output logic          svc_req,
  output logic          xrun,
  output logic [CW-1:0] level
);
  xmode_e        mode;
  logic          fill, quiet, strobe, beat;
  logic [CW-1:0] cap, thr, lvl_nxt;
  logic          push, pop, full, empty, acc_push, acc_pop;
  logic [DW-1:0] wdata, rdata;

  assign mode   = xmode_e'(xfer_mode);
  assign fill   = mode_fills(mode);
  assign quiet  = mode_quiet(mode);
  assign cap    = cfg_fifo_en ? CW'(DEPTH) : CW'(1);
  assign thr    = cfg_fifo_en ? (CW'(cfg_thr_code) + CW'(1)) : CW'(1);
  assign strobe = fill ? host_wr : host_rd;
  assign beat   = strobe && (!cfg_dma_en || dack);
  assign push   = fill ? beat : core_push;
  assign pop    = fill ? core_pop : beat;
  assign wdata  = fill ? host_wdata : core_wdata;

  xfd_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .cap(cap), .push(push), .wdata(wdata), .pop(pop),
    .rdata(rdata), .lvl(level), .lvl_nxt(lvl_nxt), .full(full), .empty(empty),
    .acc_push(acc_push), .acc_pop(acc_pop)
  );

  xfd_req #(.CW(CW)) u_req (
    .clk(clk), .rst(rst), .dma_en(cfg_dma_en), .burst_en(cfg_burst_en),
    .fill(fill), .beat(beat), .cap(cap), .thr(thr), .lvl_nxt(lvl_nxt),
    .svc_req(svc_req), .drq(drq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata_oe <= 1'b0;
      core_rvalid   <= 1'b0;
      xrun          <= 1'b0;
    end else begin
      host_rdata_oe <= !fill && !quiet && acc_pop;
      core_rvalid   <= fill && acc_pop;
      xrun          <= (!fill && core_push && full) || (fill && core_pop && empty);
    end
  end

  assign host_rdata = host_rdata_oe ? rdata : '0;
  assign core_rdata = rdata;

  p_core_overrun_r3: assert property (@(posedge clk) disable iff (rst)
    (!fill && core_push && level >= cap) |=> xrun);
  p_verify_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (quiet && beat) |=> !host_rdata_oe);
  p_bypass_one_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fifo_en && level == '0) |=> level <= CW'(1));
endmodule

// File: tb/xfer_fifo_dma_tb.sv
module xfer_fifo_dma_tb;
  logic       clk = 0, rst = 1;
  logic       cfg_fifo_en = 0, cfg_dma_en = 0, cfg_burst_en = 0;
  logic [3:0] cfg_thr_code = 0;
  logic [1:0] xfer_mode = 0;
  logic       core_push = 0, core_pop = 0, host_rd = 0, host_wr = 0, dack = 0;
  logic [7:0] core_wdata = 0, host_wdata = 0;
  logic [7:0] core_rdata, host_rdata;
  logic       core_rvalid, host_rdata_oe, drq, svc_req, xrun;
  logic [4:0] level;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_host[$];
  logic [7:0] exp_core[$];

  always #10 clk = ~clk;

  xfer_fifo_dma u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cpush(input logic [7:0] d, input bit keep);
    core_push = 1; core_wdata = d;
    if (keep) exp_host.push_back(d);
    tick(); core_push = 0;
  endtask

  task automatic hread(input bit with_dack);
    host_rd = 1; dack = with_dack; tick(); host_rd = 0; dack = 0;
  endtask

  task automatic hwrite(input logic [7:0] d, input bit with_dack);
    host_wr = 1; dack = with_dack; host_wdata = d;
    exp_core.push_back(d);
    tick(); host_wr = 0; dack = 0;
  endtask

  task automatic cpop();
    core_pop = 1; tick(); core_pop = 0;
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (host_rdata_oe) begin
      if (exp_host.size() == 0) chk(0, "R9 unexpected host byte", host_rdata, -1);
      else begin
        logic [7:0] e;
        e = exp_host.pop_front();
        chk(host_rdata == e, "R9 host data", host_rdata, e);
      end
    end
    if (core_rvalid) begin
      if (exp_core.size() == 0) chk(0, "R10 unexpected core byte", core_rdata, -1);
      else begin
        logic [7:0] e;
        e = exp_core.pop_front();
        chk(core_rdata == e, "R10 core data", core_rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst = 0; tick();
    chk(level == 0 && !drq && !svc_req && !xrun && !host_rdata_oe && !core_rvalid,
        "R1 reset state", {level, drq, svc_req, xrun}, 0);

    // bypass, read, programmed transfers
    cpush(8'hA1, 1);
    chk(level == 1, "R2 bypass holds one", level, 1);
    chk(svc_req == 1 && drq == 0, "R5 svc in PIO", svc_req, 1);
    cpush(8'hA2, 0);
    chk(xrun == 1, "R2 second byte overrun", xrun, 1);
    chk(level == 1, "R2 level unchanged", level, 1);
    hread(0);
    chk(level == 0 && svc_req == 0, "R2 drained", level, 0);

    // FIFO on, threshold code 3
    cfg_fifo_en = 1; cfg_thr_code = 3; tick();
    for (int i = 0; i < 3; i++) cpush(8'h10 + 8'(i), 1);
    chk(svc_req == 0, "R4 below threshold", svc_req, 0);
    cpush(8'h13, 1);
    chk(svc_req == 1, "R4 at threshold", svc_req, 1);
    for (int i = 4; i < 16; i++) cpush(8'h10 + 8'(i), 1);
    chk(level == 16, "R3 full level", level, 16);
    cpush(8'hEE, 0);
    chk(xrun == 1 && level == 16, "R3 overrun at full", {xrun, level}, 48);
    for (int i = 0; i < 13; i++) hread(0);
    chk(level == 3 && svc_req == 0, "R4 drops below threshold", svc_req, 0);
    for (int i = 0; i < 3; i++) hread(0);
    hread(0);
    chk(host_rdata_oe == 0 && level == 0, "R9 empty read ignored", host_rdata_oe, 0);

    // write direction, PIO
    xfer_mode = 1; tick();
    chk(svc_req == 1, "R4 fill space request", svc_req, 1);
    cpop();
    chk(xrun == 1 && core_rvalid == 0, "R3 underrun on empty pop", xrun, 1);
    for (int i = 0; i < 13; i++) hwrite(8'h40 + 8'(i), 0);
    chk(svc_req == 0 && level == 13, "R4 fill space below threshold", svc_req, 0);
    for (int i = 0; i < 13; i++) cpop();
    tick();
    chk(exp_core.size() == 0, "R10 all bytes delivered", exp_core.size(), 0);

    // DMA single, read, threshold 2
    xfer_mode = 0; cfg_dma_en = 1; cfg_thr_code = 1; tick();
    cpush(8'h61, 1);
    chk(drq == 0, "R6 drq below threshold", drq, 0);
    cpush(8'h62, 1);
    chk(drq == 1 && svc_req == 0, "R6 drq raised svc quiet", {drq, svc_req}, 2);
    cpush(8'h63, 1); cpush(8'h64, 1);
    hread(0);
    chk(level == 4 && host_rdata_oe == 0, "R6 strobe without dack ignored", level, 4);
    hread(1);
    chk(drq == 0 && level == 3, "R7 single drop", drq, 0);
    tick();
    chk(drq == 1, "R7 re-raise", drq, 1);

    // burst
    cfg_burst_en = 1;
    hread(1);
    hread(1);
    chk(drq == 1 && level == 1, "R8 burst holds below threshold", drq, 1);
    hread(1);
    chk(drq == 0 && level == 0, "R8 burst ends at empty", drq, 0);

    // write, DMA burst, threshold 4
    xfer_mode = 1; cfg_thr_code = 3; tick();
    chk(drq == 1, "R8 fill burst start", drq, 1);
    for (int i = 0; i < 15; i++) hwrite(8'h80 + 8'(i), 1);
    chk(drq == 1, "R8 burst holds while filling", drq, 1);
    hwrite(8'h8F, 1);
    chk(drq == 0 && level == 16, "R8 burst ends at full", {drq, level}, 16);
    cfg_dma_en = 0;
    for (int i = 0; i < 16; i++) cpop();
    tick();
    chk(exp_core.size() == 0, "R10 burst bytes delivered", exp_core.size(), 0);

    // verify, DMA single, threshold 1
    xfer_mode = 2; cfg_dma_en = 1; cfg_burst_en = 0; cfg_thr_code = 0; tick();
    cpush(8'hC1, 0); cpush(8'hC2, 0);
    chk(drq == 1, "R11 verify request", drq, 1);
    host_rd = 1; dack = 1; tick(); host_rd = 0; dack = 0;
    chk(host_rdata_oe == 0 && host_rdata == 0 && level == 1, "R11 verify discards",
        {host_rdata_oe, host_rdata}, 0);
    chk(drq == 0, "R7 verify single drop", drq, 0);

    tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule